// File: doc/BRIEF.md
# Add/Subtract Running-Total Accumulator with Range Lamp

The block keeps a running total in a W-bit register (8 bits by default). On each add strobe the operand presented on the input switches is either added to the stored total or taken away from it, as the direction input selects, and the W-bit result is written back. Subtraction reuses the same ripple adder: every operand bit is inverted and the carry into the lowest stage is forced high, which forms the two's complement of the operand.

A range lamp is registered together with the result. It lights when an addition produced a carry out of the top stage (the unsigned sum passed 2^W - 1), or when a subtraction produced no carry out (the unsigned result would be below zero). The carry out is never fed into the next step: each step starts from the stored W-bit value alone. A clear input empties the register so that a fresh series can begin.

Top module: `acc_top`

## Requirements
- R1: While rst is high at a rising clock edge, total and range_err both become 0.
- R2: With add_stb high, clr low and sub 0, total becomes (total + operand) mod 2^W one clock edge later.
- R3: With add_stb high, clr low and sub 1, total becomes (total - operand) mod 2^W one clock edge later, formed by inverting the operand and forcing the carry-in to 1.
- R4: On an addition step, range_err becomes 1 when total + operand is 2^W or more, and 0 otherwise (a sum of exactly 2^W - 1 leaves it 0).
- R5: On a subtraction step, range_err becomes 1 when operand is greater than total, and 0 otherwise (equal values give 0).
- R6: The carry out of one step has no effect on the next: after an overflowing addition, adding 0 returns the stored W-bit value with range_err 0.
- R7: clr high at a rising edge sets total and range_err to 0, taking priority over add_stb in the same cycle.
- R8: With add_stb and clr low, total and range_err keep their values whatever operand and sub do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| operand | input | W | Value from the input switches |
| sub | input | 1 | 0 adds the operand, 1 subtracts it |
| add_stb | input | 1 | Writes the result into the register at the next edge |
| clr | input | 1 | Synchronous clear of total and lamp |
| total | output | W | Stored running total |
| range_err | output | 1 | Range lamp for the last step |

## Verification
Every result, the total and the lamp alike, is due at the first rising edge after the cycle in which the strobe, clear or reset is presented, since both are held in one register stage with no other pipelining. The driver changes inputs on the falling edge and queues one expected pair for each cycle it drives, including idle cycles, and the monitor takes the oldest pair one time unit after the following rising edge, so each comparison lands exactly one edge after its stimulus.

// File: rtl/acc_pkg.sv
package acc_pkg;
  // direction of one accumulation step
  typedef enum logic {
    DIR_ADD = 1'b0,
    DIR_SUB = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  // subtract: invert every operand bit and force the lowest carry-in
  assign carry[0] = sub;
  assign b_eff    = b ^ {W{sub}};

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic hs;
    assign hs         = a[i] ^ b_eff[i];
    assign sum[i]     = hs ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (hs & carry[i]);
  end

  assign cout = carry[W];
endmodule

// File: rtl/acc_range.sv
module acc_range (
  input  logic sub,
  input  logic cout,
  output logic out_of_range
);
  import acc_pkg::*;
  acc_dir_e dir;
  assign dir = acc_dir_e'(sub);
  // add: carry out means the sum passed the top; sub: no carry means a borrow
  always_comb begin
    case (dir)
      DIR_ADD: out_of_range = cout;
      default: out_of_range = ~cout;
    endcase
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d_val,
  input  logic         d_flag,
  output logic [W-1:0] q_val,
  output logic         q_flag
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_val  <= '0;
      q_flag <= 1'b0;
    end else if (load) begin
      q_val  <= d_val;
      q_flag <= d_flag;
    end
  end

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q_val == '0) && !q_flag);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load) |=> $stable(q_val) && $stable(q_flag));
endmodule

// File: rtl/acc_top.sv
module acc_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] operand,
  input  logic         sub,
  input  logic         add_stb,
  input  logic         clr,
  output logic [W-1:0] total,
  output logic         range_err
);
  localparam logic [W:0] LIMIT = (W+1)'(1) << W;

  logic [W-1:0] sum_w;
  logic         carry_out;
  logic         lamp_next;

  acc_addsub #(.W(W)) u_addsub (
    .a    (total),
    .b    (operand),
    .sub  (sub),
    .sum  (sum_w),
    .cout (carry_out)
  );

  acc_range u_range (
    .sub          (sub),
    .cout         (carry_out),
    .out_of_range (lamp_next)
  );

  acc_reg #(.W(W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load   (add_stb),
    .d_val  (sum_w),
    .d_flag (lamp_next),
    .q_val  (total),
    .q_flag (range_err)
  );

  // R2
  add_value_chk: assert property (@(posedge clk) disable iff (rst)
    (add_stb && !clr && !sub) |=> total == W'($past(total) + $past(operand)));

  // R3
  sub_value_chk: assert property (@(posedge clk) disable iff (rst)
    (add_stb && !clr && sub) |=> total == W'($past(total) - $past(operand)));

  // R4
  add_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    (add_stb && !clr && !sub) |=>
      range_err == (({1'b0, $past(total)} + {1'b0, $past(operand)}) >= LIMIT));

  // R5
  sub_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    (add_stb && !clr && sub) |=> range_err == ($past(operand) > $past(total)));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (total == '0) && !range_err);
endmodule

// File: tb/sim_acc_top.sv
module sim_acc_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] operand = '0;
  logic         sub = 1'b0;
  logic         add_stb = 1'b0;
  logic         clr = 1'b0;
  logic [W-1:0] total;
  logic         range_err;

  int total_n = 0;
  int bad_n   = 0;

  logic [W:0] exp_q[$];
  string      tag_q[$];
  logic [W-1:0] m_tot = '0;
  logic         m_err = 1'b0;

  always #2.5 clk = ~clk;

  acc_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .operand(operand), .sub(sub),
    .add_stb(add_stb), .clr(clr), .total(total), .range_err(range_err)
  );

  task automatic compare(string tag, logic [W:0] got, logic [W:0] exp);
    total_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s: total/lamp actual=%0d/%0b expected=%0d/%0b",
               tag, got[W-1:0], got[W], exp[W-1:0], exp[W]);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(string tag, logic [W-1:0] op, logic s, logic a, logic c);
    logic [W:0] wide;
    @(negedge clk);
    operand = op; sub = s; add_stb = a; clr = c;
    if (c) begin
      m_tot = '0; m_err = 1'b0;
    end else if (a) begin
      if (!s) begin
        wide  = {1'b0, m_tot} + {1'b0, op};
        m_err = wide[W];
        m_tot = wide[W-1:0];
      end else begin
        m_err = op > m_tot;
        m_tot = m_tot - op;
      end
    end
    exp_q.push_back({m_err, m_tot});
    tag_q.push_back(tag);
  endtask

  // monitor: one result per driven cycle, due one edge later
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare(t, {range_err, total}, e);
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    operand = 8'hA5; add_stb = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", {range_err, total}, '0);
    rst = 1'b0; add_stb = 1'b0;

    step("R2", 8'd200, 1'b0, 1'b1, 1'b0); // 200
    step("R4", 8'd100, 1'b0, 1'b1, 1'b0); // 44, lamp
    step("R8", 8'd77,  1'b1, 1'b0, 1'b0); // hold 44, lamp
    step("R8", 8'd3,   1'b0, 1'b0, 1'b0); // hold
    step("R6", 8'd0,   1'b0, 1'b1, 1'b0); // 44, lamp off
    step("R3", 8'd4,   1'b1, 1'b1, 1'b0); // 40
    step("R5", 8'd40,  1'b1, 1'b1, 1'b0); // 0, equal -> off
    step("R5", 8'd1,   1'b1, 1'b1, 1'b0); // 255, lamp
    step("R4", 8'd1,   1'b0, 1'b1, 1'b0); // 0, exactly 256
    step("R4", 8'd255, 1'b0, 1'b1, 1'b0); // 255, lamp off
    step("R7", 8'd5,   1'b0, 1'b1, 1'b1); // clear wins
    step("R2", 8'd55,  1'b0, 1'b1, 1'b0); // 55
    step("R7", 8'd9,   1'b1, 1'b0, 1'b1); // plain clear
    for (int i = 0; i < 40; i++) begin
      logic s;
      s = (i % 3 == 0);
      step(s ? "R3" : "R2", 8'((i * 37 + 11) % 256), s, 1'b1, 1'b0);
      if (i % 7 == 3) step("R8", 8'(i), ~s, 1'b0, 1'b0);
    end
    step("R8", 8'd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule